// File: doc/BRIEF.md
# Bus Transaction Timeout Monitor

This block sits beside a bus master and watches each outstanding transaction for two failure modes. In the first, the target takes too long to signal ready. In the second, the target keeps terminating the transaction with retry. Each failure mode has its own 8-bit threshold register, and software programs both through a small byte-wide register port. When either limit is crossed, the block sets a sticky fatal-error flag. The flag stays set until software writes 1 to its clear bit.

The ready-wait limit is coarse. The register value supplies the upper bits of a wider cycle limit, and the low bits of that limit are always zero, so the limit is a multiple of 32 bus clocks. A register value of zero turns the ready-wait check off. The retry limit is a plain count, and a value of zero turns the retry check off. All inputs are synchronous to the bus clock. Bus sequencing and arbitration are handled elsewhere.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset, the ready-wait register at offset 40h reads 00h, the retry register at offset 41h reads 80h, and the flag is 0 (fatal_err_o low, bit 0 of offset 42h reads 0).
- R2: A write with reg_we_i high updates the register at offset 40h or 41h on the next clock edge. reg_rdata_o shows the addressed register combinationally. Offset 42h reads the flag in bit 0 with the other bits 0, and every other offset reads 00h.
- R3: A waiting cycle is a cycle with txn_active_i=1 and trdy_i=0. With a nonzero ready-wait register value V, the limit is L = V*32 clocks. Exactly L consecutive waiting cycles leave the flag clear. The (L+1)th consecutive waiting cycle sets the flag, and fatal_err_o is high after that clock edge.
- R4: The run of waiting cycles restarts from zero whenever trdy_i is high or txn_active_i is low in a cycle.
- R5: A ready-wait register value of 00h disables the ready-wait check for any length of wait.
- R6: A retry is a cycle with txn_active_i=1 and retry_i=1. With a nonzero retry register value N, the first N retries leave the flag clear. Retry number N+1 sets the flag after its clock edge.
- R7: A clean completion resets the retry count to zero. A clean completion is a cycle with txn_active_i=1, trdy_i=1 and retry_i=0.
- R8: A retry register value of 00h disables the retry check.
- R9: Once set, the flag stays set. A write to offset 42h with bit 0 = 1 clears it. A write to offset 42h with bit 0 = 0 leaves it unchanged. If a new error occurs in the same cycle as a clear, the flag stays set.
- R10: fatal_err_o rises only in the cycle after a ready-wait or retry limit is crossed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| txn_active_i | input | 1 | A transaction is outstanding |
| trdy_i | input | 1 | Target ready |
| retry_i | input | 1 | Target terminated the transaction with retry |
| fatal_err_o | output | 1 | Sticky unrecoverable-error flag |

## Verification
The bench builds the block with its default parameters: an 8-bit configuration width and 5 zero low bits, which gives a 13-bit ready-wait timer. With these values the smallest nonzero ready-wait limit is 32 clocks and the largest is 8160 clocks, and both edges can be reached in a short run. The bench checks each limit one cycle below and one cycle above it. It also probes the retry limit at a small programmed value, so that the restart on a clean completion and the disable value can both be driven within a few dozen cycles.

// File: rtl/btm_pkg.sv
package btm_pkg;
  localparam int unsigned CFG_W = 8;
  localparam int unsigned ADDR_W = 8;

  typedef logic [CFG_W-1:0] cfg_byte_t;

  typedef struct packed {
    cfg_byte_t wait_lim;
    cfg_byte_t retry_lim;
  } btm_cfg_t;
endpackage

// File: rtl/btm_wait_timer.sv
module btm_wait_timer #(
  parameter int unsigned CFG_W = 8,
  parameter int unsigned LSB_ZERO = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             ready_i,
  input  logic [CFG_W-1:0] lim_i,
  output logic             hit_o
);
  localparam int unsigned TW = CFG_W + LSB_ZERO;
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] limit;
  logic          waiting;

  assign limit   = TW'(lim_i) << LSB_ZERO;
  assign waiting = active_i & ~ready_i;
  // cnt_q holds the number of earlier consecutive waiting cycles
  assign hit_o   = waiting && (lim_i != '0) && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!waiting)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/btm_retry_counter.sv
module btm_retry_counter #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             ready_i,
  input  logic             retry_i,
  input  logic [CFG_W-1:0] lim_i,
  output logic             hit_o
);
  localparam logic [CFG_W-1:0] CNT_MAX = '1;

  logic [CFG_W-1:0] cnt_q;
  logic             retry_seen;
  logic             clean_done;

  assign retry_seen = active_i & retry_i;
  assign clean_done = active_i & ready_i & ~retry_i;
  assign hit_o      = retry_seen && (lim_i != '0) && (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (retry_seen) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
    else if (clean_done)   cnt_q <= '0;
  end
endmodule

// File: rtl/btm_cfg_regs.sv
module btm_cfg_regs
  import btm_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WAIT_OFF  = 8'h40,
  parameter logic [ADDR_W-1:0] RETRY_OFF = 8'h41,
  parameter logic [ADDR_W-1:0] ERR_OFF   = 8'h42,
  parameter cfg_byte_t         WAIT_RST  = 8'h00,
  parameter cfg_byte_t         RETRY_RST = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  cfg_byte_t         wdata_i,
  input  logic              err_i,
  output btm_cfg_t          cfg_o,
  output cfg_byte_t         rdata_o,
  output logic              err_clr_o
);
  btm_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.wait_lim  <= WAIT_RST;
      cfg_q.retry_lim <= RETRY_RST;
    end else if (we_i) begin
      if (addr_i == WAIT_OFF)  cfg_q.wait_lim  <= wdata_i;
      if (addr_i == RETRY_OFF) cfg_q.retry_lim <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == WAIT_OFF)       rdata_o = cfg_q.wait_lim;
    else if (addr_i == RETRY_OFF) rdata_o = cfg_q.retry_lim;
    else if (addr_i == ERR_OFF)   rdata_o = {{(CFG_W-1){1'b0}}, err_i};
  end

  assign err_clr_o = we_i && (addr_i == ERR_OFF) && wdata_i[0];
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
  import btm_pkg::*;
#(
  parameter int unsigned       WAIT_LSB  = 5,
  parameter logic [ADDR_W-1:0] WAIT_OFF  = 8'h40,
  parameter logic [ADDR_W-1:0] RETRY_OFF = 8'h41,
  parameter logic [ADDR_W-1:0] ERR_OFF   = 8'h42,
  parameter cfg_byte_t         RETRY_RST = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CFG_W-1:0]  reg_wdata_i,
  output logic [CFG_W-1:0]  reg_rdata_o,
  input  logic              txn_active_i,
  input  logic              trdy_i,
  input  logic              retry_i,
  output logic              fatal_err_o
);
  btm_cfg_t cfg;
  logic     err_q;
  logic     err_clr;
  logic     wait_hit;
  logic     retry_hit;

  btm_cfg_regs #(
    .WAIT_OFF (WAIT_OFF),
    .RETRY_OFF(RETRY_OFF),
    .ERR_OFF  (ERR_OFF),
    .WAIT_RST (8'h00),
    .RETRY_RST(RETRY_RST)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .err_i    (err_q),
    .cfg_o    (cfg),
    .rdata_o  (reg_rdata_o),
    .err_clr_o(err_clr)
  );

  btm_wait_timer #(
    .CFG_W   (CFG_W),
    .LSB_ZERO(WAIT_LSB)
  ) u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(txn_active_i),
    .ready_i (trdy_i),
    .lim_i   (cfg.wait_lim),
    .hit_o   (wait_hit)
  );

  btm_retry_counter #(
    .CFG_W(CFG_W)
  ) u_retry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(txn_active_i),
    .ready_i (trdy_i),
    .retry_i (retry_i),
    .lim_i   (cfg.retry_lim),
    .hit_o   (retry_hit)
  );

  // a new error wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   err_q <= 1'b0;
    else if (wait_hit | retry_hit) err_q <= 1'b1;
    else if (err_clr)              err_q <= 1'b0;
  end

  assign fatal_err_o = err_q;
endmodule

// File: rtl/btm_checker.sv
module btm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic       txn_active_i,
  input logic       trdy_i,
  input logic       retry_i,
  input logic       fatal_err_o,
  input logic       wait_hit,
  input logic       retry_hit,
  input logic [7:0] wait_lim,
  input logic [7:0] retry_lim
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_addr_i == 8'h42) && reg_wdata_i[0];

  // R9: flag holds unless a clear write arrives
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_err_o && !clr_wr |=> fatal_err_o);

  // R9: an error in the same cycle as a clear keeps the flag set
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_hit || retry_hit) |=> fatal_err_o);

  // R10: a rise of the flag needs a limit crossing one cycle earlier
  a_r10_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fatal_err_o ##1 fatal_err_o |-> $past(wait_hit || retry_hit));

  // R5: zero ready-wait register never reports a wait hit
  a_r5_wait_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_lim == 8'h00 |-> !wait_hit);

  // R8: zero retry register never reports a retry hit
  a_r8_retry_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_lim == 8'h00 |-> !retry_hit);

  // R4: no wait hit while target is ready or idle
  a_r4_no_hit_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trdy_i || !txn_active_i) |-> !wait_hit);

  // R6: retry hit only on a retry cycle
  a_r6_hit_on_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_hit |-> (retry_i && txn_active_i));
endmodule

bind bus_timeout_mon btm_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .txn_active_i(txn_active_i),
  .trdy_i      (trdy_i),
  .retry_i     (retry_i),
  .fatal_err_o (fatal_err_o),
  .wait_hit    (wait_hit),
  .retry_hit   (retry_hit),
  .wait_lim    (cfg.wait_lim),
  .retry_lim   (cfg.retry_lim)
);

// File: tb/bus_timeout_mon_tb.sv
module bus_timeout_mon_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       active = 1'b0;
  logic       trdy = 1'b0;
  logic       retry = 1'b0;
  logic       fatal;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_timeout_mon u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .txn_active_i(active),
    .trdy_i      (trdy),
    .retry_i     (retry),
    .fatal_err_o (fatal)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] a;
    logic [7:0] d;
    logic [7:0] exp;
  } vec_t;

  // R2 register access table
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h40, 8'hA5, 8'h00},
    '{1'b0, 8'h40, 8'h00, 8'hA5},
    '{1'b1, 8'h41, 8'h3C, 8'h00},
    '{1'b0, 8'h41, 8'h00, 8'h3C},
    '{1'b0, 8'h40, 8'h00, 8'hA5},
    '{1'b1, 8'h43, 8'hFF, 8'h00},
    '{1'b0, 8'h43, 8'h00, 8'h00},
    '{1'b0, 8'h42, 8'h00, 8'h00},
    '{1'b0, 8'h41, 8'h00, 8'h3C}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    active = 1'b0; trdy = 1'b0; retry = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cycles(input int n);
    active = 1'b1; trdy = 1'b0; retry = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic retries(input int n);
    active = 1'b1; trdy = 1'b0;
    for (int i = 0; i < n; i++) begin
      retry = 1'b1;
      @(negedge clk);
      retry = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic clear_err();
    idle(1);
    wr_reg(8'h42, 8'h01);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(8'h40, d); check("R1 wait reg", d, 8'h00);
    rd_reg(8'h41, d); check("R1 retry reg", d, 8'h80);
    rd_reg(8'h42, d); check("R1 flag reg", d, 8'h00);
    check("R1 fatal", fatal, 1'b0);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr_reg(VECS[i].a, VECS[i].d);
      else begin
        rd_reg(VECS[i].a, d);
        check("R2 register read", d, VECS[i].exp);
      end
    end

    // both checks off
    wr_reg(8'h40, 8'h00);
    wr_reg(8'h41, 8'h00);

    // R5 wait disabled
    wait_cycles(300);
    check("R5 wait disabled", fatal, 1'b0);
    // R8 retry disabled
    retries(300);
    check("R8 retry disabled", fatal, 1'b0);
    idle(2);

    // R3 smallest limit: 32 clocks
    wr_reg(8'h40, 8'h01);
    wait_cycles(32);
    check("R3 exactly 32 waits", fatal, 1'b0);
    trdy = 1'b1; @(negedge clk);
    wait_cycles(32);
    check("R3 32 waits after ready", fatal, 1'b0);
    @(negedge clk);
    check("R3 33rd wait sets flag", fatal, 1'b1);

    // R9 write 0 has no effect, write 1 clears
    idle(1);
    wr_reg(8'h42, 8'h00);
    check("R9 write 0 keeps flag", fatal, 1'b1);
    rd_reg(8'h42, d); check("R9 flag readback", d, 8'h01);
    idle(5);
    check("R9 flag sticky while idle", fatal, 1'b1);
    wr_reg(8'h42, 8'h01);
    check("R9 write 1 clears", fatal, 1'b0);

    // R4 restart on idle gap and on ready
    wait_cycles(20); idle(1); wait_cycles(20);
    check("R4 idle gap restarts wait", fatal, 1'b0);
    trdy = 1'b1; @(negedge clk);
    wait_cycles(30); trdy = 1'b1; @(negedge clk); wait_cycles(30);
    check("R4 ready restarts wait", fatal, 1'b0);
    idle(1);

    // R3 largest limit: 8160 clocks
    wr_reg(8'h40, 8'hFF);
    wait_cycles(8160);
    check("R3 8160 waits", fatal, 1'b0);
    @(negedge clk);
    check("R3 8161st wait sets flag", fatal, 1'b1);
    clear_err();
    wr_reg(8'h40, 8'h00);

    // R6 retry limit 3
    wr_reg(8'h41, 8'h03);
    retries(3);
    check("R6 three retries", fatal, 1'b0);
    active = 1'b1; retry = 1'b1; @(negedge clk); retry = 1'b0;
    check("R6 fourth retry sets flag", fatal, 1'b1);
    clear_err();

    // R7 clean completion restarts retry count
    active = 1'b1; trdy = 1'b1; @(negedge clk);
    retries(3);
    trdy = 1'b1; @(negedge clk);
    retries(3);
    check("R7 count restarts on clean completion", fatal, 1'b0);
    retries(1);
    check("R7 limit crossed after restart", fatal, 1'b1);
    idle(1);

    // R10 flag rises only from a limit crossing
    clear_err();
    wr_reg(8'h41, 8'h00);
    active = 1'b1; trdy = 1'b1; retry = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 no cause no flag", fatal, 1'b0);
    idle(1);

    // R1 reset mid-run
    wr_reg(8'h40, 8'h07);
    wr_reg(8'h41, 8'h01);
    retries(2);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rd_reg(8'h40, d); check("R1 wait reg after reset", d, 8'h00);
    rd_reg(8'h41, d); check("R1 retry reg after reset", d, 8'h80);
    check("R1 fatal after reset", fatal, 1'b0);

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule